// File: doc/BRIEF.md
# Seconds Real-Time Counter with Compare Alarm

This block keeps wall-clock time as a single 32-bit count of seconds. One of two timing enables (a 32.768 kHz strobe or a strobe derived from a faster clock) is divided down to one tick per second, and each tick advances the count. Software loads a starting time, programs one compare value, and reads back the running time and an alarm status bit. When the count reaches the compare value, a sticky status bit is set. A level interrupt is driven while that status is pending, the alarm is enabled and the alarm is unmasked.

A build option keeps the running count and the compare value in Gray code. Software then writes and reads those two values as Gray words, and the block decodes them internally before it increments or compares. Register access uses a request channel with valid/ready and a read-response channel with valid/ready. A request is taken on a cycle where both `req_valid` and `req_ready` are high. Only reads return a response. `req_ready` is low while an earlier read response waits for `rsp_ready`, and that response holds its data until it is taken.

Top module: `sec_rtc`

## Requirements
- R1: After reset, control reads 0, the mask reads 1, status reads 0, the time reads 0 and `irq` is 0.
- R2: Control word 0x0, bit 12 is the run enable, and its written value reads back on the next read. While the run enable is 1, the count advances by one after every PRESC_DIV cycles that have the selected timing enable high. While it is 0, the count and the prescaler hold.
- R3: Control bit 8 high makes `tick_hi` the prescaler input. Bit 8 low makes `tick_lo` the prescaler input. The unselected input has no effect.
- R4: A write to word 0x1 replaces the running count on the following cycle and restarts the one-second prescaler from zero.
- R5: With GRAY_STORE=1, the words written to 0x1 and 0x2 and the time read from 0xD are Gray code, g = b ^ (b >> 1). Counting follows binary order. Word 0x2 reads back the stored alarm word.
- R6: The count wraps from 0xFFFFFFFF to 0.
- R7: Status bit 0 (word 0xC) is set on the tick that moves the binary count onto the nonzero binary alarm value (word 0x2). It stays set until cleared. An alarm value of 0 never matches.
- R8: `irq` is 1 exactly when status bit 0 is 1, control bit 0 (alarm enable) is 1 and mask bit 0 (word 0x8) is 0.
- R9: A write to word 0x9 with bit 0 set clears status bit 0. The same write with bit 0 clear has no effect.
- R10: While a read response is held with `rsp_ready` low, `req_ready` is 0 and `rsp_valid` and `rsp_rdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_lo | input | 1 | 32.768 kHz timing enable, one cycle wide |
| tick_hi | input | 1 | Timing enable derived from the fast clock, one cycle wide |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
The hardest situation to reach is a match while the count is in Gray form: the status has to set on the exact second the decoded count lands on the decoded alarm. The same check must cover a zero alarm across the 0xFFFFFFFF wrap, which must not set status. The stimulus preloads the count a few seconds before the target and feeds exact numbers of timing enables, so each second boundary falls on a known cycle. It reads status just before and just after that second. It also preloads 0xFFFFFFFE in Gray form and steps across the wrap with the alarm at zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_CTRL  = 4'h0,
    RG_LOAD  = 4'h1,
    RG_ALARM = 4'h2,
    RG_MASK  = 4'h8,
    RG_CLEAR = 4'h9,
    RG_STAT  = 4'hC,
    RG_TIME  = 4'hD
  } rtc_reg_e;

  localparam int unsigned CB_ALM_EN = 0;
  localparam int unsigned CB_SEL_HI = 8;
  localparam int unsigned CB_RUN    = 12;

  typedef struct packed {
    logic run;
    logic sel_hi;
    logic alm_en;
  } rtc_ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic sel_hi,
  input  logic tick_lo,
  input  logic tick_hi,
  output logic sec_tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_sel;

  assign tick_sel = sel_hi ? tick_hi : tick_lo;
  assign sec_tick = run && tick_sel && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && tick_sel) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_code_view.sv
module rtc_code_view #(
  parameter int unsigned W    = 32,
  parameter bit          GRAY = 1'b0
) (
  input  logic [W-1:0] code,
  output logic [W-1:0] bin
);
  generate
    if (GRAY) begin : g_gray
      always_comb begin
        bin[W-1] = code[W-1];
        for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ code[i];
      end
    end else begin : g_plain
      assign bin = code;
    end
  endgenerate
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned W    = 32,
  parameter bit          GRAY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_code,
  input  logic         step,
  output logic [W-1:0] code_q,
  output logic [W-1:0] bin_next
);
  logic [W-1:0] bin_now;
  logic [W-1:0] code_next;

  rtc_code_view #(.W(W), .GRAY(GRAY)) u_view (
    .code(code_q),
    .bin (bin_now)
  );

  assign bin_next = bin_now + 1'b1;

  generate
    if (GRAY) begin : g_enc
      assign code_next = bin_next ^ (bin_next >> 1);
    end else begin : g_raw
      assign code_next = bin_next;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= load_code;
    else if (step) code_q <= code_next;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] bin_next,
  input  logic [W-1:0] alarm_bin,
  input  logic         clear,
  input  logic         alm_en,
  input  logic         mask,
  output logic         status,
  output logic         irq
);
  logic hit;

  assign hit = step && (alarm_bin != '0) && (bin_next == alarm_bin);
  assign irq = status && alm_en && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= 1'b0;
    else if (hit)   status <= 1'b1;
    else if (clear) status <= 1'b0;
  end
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_rdata,
  input  logic [W-1:0]      time_code,
  input  logic              status,
  output rtc_ctrl_t         ctrl,
  output logic [W-1:0]      alarm_code,
  output logic              mask,
  output logic              load_stb,
  output logic              clear_stb
);
  logic         take, wr, rd;
  logic [W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr        = take && req_write;
  assign rd        = take && !req_write;
  assign load_stb  = wr && (req_addr == RG_LOAD);
  assign clear_stb = wr && (req_addr == RG_CLEAR) && req_wdata[0];

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      RG_CTRL: begin
        rd_mux[CB_ALM_EN] = ctrl.alm_en;
        rd_mux[CB_SEL_HI] = ctrl.sel_hi;
        rd_mux[CB_RUN]    = ctrl.run;
      end
      RG_ALARM: rd_mux    = alarm_code;
      RG_MASK:  rd_mux[0] = mask;
      RG_STAT:  rd_mux[0] = status;
      RG_TIME:  rd_mux    = time_code;
      default:  rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      ctrl       <= '0;
      alarm_code <= '0;
      mask       <= 1'b1;
    end else begin
      if (rd) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (wr) begin
        case (req_addr)
          RG_CTRL: begin
            ctrl.alm_en <= req_wdata[CB_ALM_EN];
            ctrl.sel_hi <= req_wdata[CB_SEL_HI];
            ctrl.run    <= req_wdata[CB_RUN];
          end
          RG_ALARM: alarm_code <= req_wdata;
          RG_MASK:  mask       <= req_wdata[0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned TIME_W     = 32,
  parameter int unsigned PRESC_DIV  = 32768,
  parameter bit          GRAY_STORE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_lo,
  input  logic              tick_hi,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TIME_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TIME_W-1:0] rsp_rdata,
  output logic              irq
);
  rtc_ctrl_t         ctrl_q;
  logic [TIME_W-1:0] alarm_code, alarm_bin, time_code, bin_next;
  logic              mask_q, load_stb, clear_stb, sec_tick, alm_status;

  rtc_regif #(.W(TIME_W)) u_regif (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .time_code (time_code),
    .status    (alm_status),
    .ctrl      (ctrl_q),
    .alarm_code(alarm_code),
    .mask      (mask_q),
    .load_stb  (load_stb),
    .clear_stb (clear_stb)
  );

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk, .rst_n,
    .run     (ctrl_q.run),
    .restart (load_stb),
    .sel_hi  (ctrl_q.sel_hi),
    .tick_lo, .tick_hi,
    .sec_tick(sec_tick)
  );

  rtc_time_core #(.W(TIME_W), .GRAY(GRAY_STORE)) u_core (
    .clk, .rst_n,
    .load     (load_stb),
    .load_code(req_wdata),
    .step     (sec_tick),
    .code_q   (time_code),
    .bin_next (bin_next)
  );

  rtc_code_view #(.W(TIME_W), .GRAY(GRAY_STORE)) u_alm_view (
    .code(alarm_code),
    .bin (alarm_bin)
  );

  rtc_alarm #(.W(TIME_W)) u_alarm (
    .clk, .rst_n,
    .step     (sec_tick),
    .bin_next (bin_next),
    .alarm_bin(alarm_bin),
    .clear    (clear_stb),
    .alm_en   (ctrl_q.alm_en),
    .mask     (mask_q),
    .status   (alm_status),
    .irq      (irq)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_rdata,
  input logic [W-1:0] req_wdata,
  input logic [W-1:0] time_code,
  input logic         status,
  input logic         alm_en,
  input logic         mask,
  input logic         run,
  input logic         load_stb,
  input logic         clear_stb,
  input logic         sec_tick
);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status && alm_en && !mask));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_stb) |=> $stable(time_code));

  p_tick_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> run);

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (time_code == $past(req_wdata)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clear_stb) |=> status);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_stb && !sec_tick) |=> !status);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind sec_rtc sec_rtc_chk #(.W(TIME_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .req_wdata(req_wdata),
  .time_code(time_code),
  .status   (alm_status),
  .alm_en   (ctrl_q.alm_en),
  .mask     (mask_q),
  .run      (ctrl_q.run),
  .load_stb (load_stb),
  .clear_stb(clear_stb),
  .sec_tick (sec_tick)
);

// File: tb/tb_sec_rtc.sv
`timescale 1ns/1ps
module tb_sec_rtc;
  localparam int unsigned DIV = 4;
  localparam logic [3:0] A_CTRL = 4'h0, A_LOAD = 4'h1, A_ALM = 4'h2,
                         A_MASK = 4'h8, A_CLR = 4'h9, A_STAT = 4'hC, A_TIME = 4'hD;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_lo = 1'b0, tick_hi = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model state (binary)
  int unsigned m_pre = 0;
  logic [31:0] m_time = '0, m_alm = '0;
  bit m_run = 0, m_sel = 0, m_aen = 0, m_mask = 1, m_stat = 0;

  sec_rtc #(.TIME_W(32), .PRESC_DIV(DIV), .GRAY_STORE(1'b1)) dut (
    .clk, .rst_n, .tick_lo, .tick_hi, .req_valid, .req_ready, .req_write,
    .req_addr, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .irq
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] to_g(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_g(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data at each response handshake
  always @(posedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    case (a)
      A_CTRL: begin m_aen = d[0]; m_sel = d[8]; m_run = d[12]; end
      A_LOAD: begin m_time = from_g(d); m_pre = 0; end
      A_ALM:  m_alm = from_g(d);
      A_MASK: m_mask = d[0];
      A_CLR:  if (d[0]) m_stat = 0;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic rd_time(input string tag);
    rd(A_TIME, to_g(m_time), tag);
  endtask

  task automatic pulse(input bit lo, input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      tick_lo = lo; tick_hi = hi;
      @(negedge clk);
      if (m_run && (m_sel ? hi : lo)) begin
        m_pre++;
        if (m_pre == DIV) begin
          m_pre = 0;
          m_time = m_time + 1;
          if (m_time == m_alm && m_alm != 0) m_stat = 1;
        end
      end
    end
    tick_lo = 0; tick_hi = 0;
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {31'b0, irq}, {31'b0, m_stat & m_aen & ~m_mask});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_MASK, 32'h1, "R1 mask");
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_TIME, 32'h0, "R1 time");
    chk_irq("R1 irq");
    // R2 hold while stopped
    wr(A_LOAD, to_g(32'd100));
    pulse(1, 0, 8);
    rd_time("R2 hold when stopped");
    wr(A_CTRL, 32'h1000);
    rd(A_CTRL, 32'h1000, "R2 run readback");
    pulse(1, 0, 4);
    rd_time("R2 one second");
    pulse(1, 0, 12);
    rd_time("R5 gray counting");
    // R4 preload restarts prescaler
    pulse(1, 0, 2);
    wr(A_LOAD, to_g(32'd200));
    pulse(1, 0, 3);
    rd_time("R4 restart no step");
    pulse(1, 0, 1);
    rd_time("R4 restart step");
    // R7/R8/R9 alarm
    wr(A_ALM, to_g(32'd203));
    rd(A_ALM, to_g(32'd203), "R5 alarm readback");
    wr(A_MASK, 32'h0);
    wr(A_CTRL, 32'h1001);
    pulse(1, 0, 4);
    rd(A_STAT, 32'h0, "R7 before match");
    chk_irq("R8 before match");
    pulse(1, 0, 4);
    rd(A_STAT, 32'h1, "R7 at match");
    chk_irq("R8 raised");
    pulse(1, 0, 4);
    rd(A_STAT, 32'h1, "R7 sticky");
    wr(A_CLR, 32'h0);
    rd(A_STAT, 32'h1, "R9 clear with zero ignored");
    wr(A_CLR, 32'h1);
    rd(A_STAT, 32'h0, "R9 cleared");
    chk_irq("R9 irq dropped");
    // R8 masking and enable gating
    wr(A_ALM, to_g(32'd206));
    wr(A_MASK, 32'h1);
    pulse(1, 0, 8);
    rd(A_STAT, 32'h1, "R7 match while masked");
    chk_irq("R8 masked");
    wr(A_MASK, 32'h0);
    chk_irq("R8 unmasked");
    wr(A_CTRL, 32'h1000);
    chk_irq("R8 alarm disabled");
    wr(A_CLR, 32'h1);
    // R6 wrap with zero alarm
    wr(A_ALM, 32'h0);
    wr(A_LOAD, to_g(32'hFFFF_FFFE));
    pulse(1, 0, 4);
    rd_time("R6 top value");
    pulse(1, 0, 4);
    rd_time("R6 wrapped");
    rd(A_STAT, 32'h0, "R7 zero alarm no match");
    // R3 tick source select
    wr(A_CTRL, 32'h1100);
    pulse(1, 0, 4);
    rd_time("R3 low input ignored");
    pulse(0, 1, 4);
    rd_time("R3 high input counts");
    // R10 back-pressure
    rsp_ready = 0;
    exp_q.push_back(to_g(m_time)); tag_q.push_back("R10 held data");
    req_valid = 1; req_write = 0; req_addr = A_TIME;
    @(negedge clk);
    req_valid = 0;
    check("R10 req_ready low", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    check("R10 rsp held", {31'b0, rsp_valid}, 32'h1);
    check("R10 data held", rsp_rdata, to_g(m_time));
    rsp_ready = 1;
    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule